// File: doc/BRIEF.md
# Ordered Destination-Register Scoreboard

This block records the destination register of every instruction that has entered an in-order pipeline but has not yet written back. The operand-fetch stage presents two source register indices and gets back one stall bit. The bit is high when either source names a destination that is still pending, so the stage holds the instruction until the value has been written.

Records sit in a small circular queue in program order. A new record is inserted when an instruction passes operand fetch. The write-back stage retires the oldest record, and it is the only source of retirement. An instruction that was squashed earlier in the pipe keeps its record and retires it at write-back like any other instruction. A retirement in a cycle is applied before that cycle's search, in the same way a pipeline FIFO dequeues before it enqueues. Because of this, a register whose only pending writer is retiring in the current cycle does not stall.

An instruction with no destination register still takes a slot, so that retirement stays strictly in order. Register 0 is hard-wired and never causes a stall.

Top module: `rr_scoreboard`

## Requirements
- R1: After reset the queue is empty: `stall` is 0 for every pair of source indices and `ins_ready` is 1.
- R2: From the cycle after an accepted insert with `ins_has_dst`=1, a search whose source index equals the inserted `ins_dst` gives `stall`=1.
- R3: While `rm_req` is high and the queue is not empty, the oldest record is left out of that cycle's search. A source index that matches only the oldest record gives `stall`=0 in that cycle. A match in any younger record still gives `stall`=1.
- R4: A retirement removes only the oldest record. Younger records keep matching in the cycles after it.
- R5: An insert with `ins_has_dst`=0 takes one slot and counts toward the DEPTH limit, but it never matches a search.
- R6: A source index of 0 never causes a stall, even when a record holds destination 0.
- R7: With DEPTH records held and `rm_req` low, `ins_ready` is 0 and an insert is refused. With `rm_req` high, `ins_ready` is 1 and an insert in that same cycle is accepted, so the queue stays full.
- R8: A retirement request while the queue is empty is ignored: the queue stays empty and later inserts are counted from zero.
- R9: `stall` is the OR of the matches for `src_a` and `src_b`, so a match on either source alone is enough to stall.
- R10: An insert does not affect the search made in the cycle in which it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ins_req | input | 1 | Request to insert a record |
| ins_has_dst | input | 1 | The instruction writes a destination register |
| ins_dst | input | 5 | Destination register index |
| ins_ready | output | 1 | An insert is accepted this cycle |
| rm_req | input | 1 | Write-back retires the oldest record |
| src_a | input | 5 | First source register index to search |
| src_b | input | 5 | Second source register index to search |
| stall | output | 1 | A source matches a pending destination |

## Verification
Errors in the head or tail pointer show up at the ports within one or two cycles. The wrong record is retired, so a younger destination stops stalling too early, or an older one keeps stalling after it should have been released. A wrong occupancy count shows up as `ins_ready` dropping one insert too early or too late when the queue is filled to DEPTH, including when it is filled straight after a retirement request on an empty queue. Applying the retirement after the search, instead of before it, only shows in the retirement cycle itself. For that reason the bench samples `stall` inside that cycle, both when the oldest record is the only match and when a younger record also matches.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int REG_IDX_W = 5;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef struct packed {
        logic     has_dst;
        reg_idx_t dst;
    } sb_entry_t;

    // a held record hazards a source only if it writes a real register
    function automatic logic entry_hits(sb_entry_t e, reg_idx_t a, reg_idx_t b);
        logic live;
        live = e.has_dst && (e.dst != '0);
        return live && ((e.dst == a) || (e.dst == b));
    endfunction

endpackage

// File: rtl/sb_ptr_ctrl.sv
module sb_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ins_req,
    input  logic          rm_req,
    output logic [PW-1:0] head,
    output logic [PW-1:0] tail,
    output logic          ins_fire,
    output logic          rm_fire,
    output logic          empty,
    output logic          ins_ready
);

    logic [CW-1:0] count;
    logic          full;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));
    assign rm_fire   = rm_req && !empty;
    assign ins_ready = !full || rm_fire;
    assign ins_fire  = ins_req && ins_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (rm_fire)  head <= bump(head);
            if (ins_fire) tail <= bump(tail);
            case ({ins_fire, rm_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: an accepted insert with no retirement grows occupancy by one
    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        (ins_fire && !rm_fire) |=> (count == $past(count) + CW'(1)));

    // R7: a refused insert leaves occupancy unchanged at the limit
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (ins_req && !ins_ready) |=> (count == CW'(DEPTH)));

    // R8: a retirement request on an empty queue leaves it empty
    p_empty_remove_r8: assert property (@(posedge clk) disable iff (rst)
        (rm_req && empty && !ins_req) |=> empty);

endmodule

// File: rtl/sb_slot_array.sv
module sb_slot_array
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [PW-1:0]               wr_ptr,
    input  sb_entry_t                   wr_entry,
    input  logic                        clr_en,
    input  logic [PW-1:0]               clr_ptr,
    output sb_entry_t [DEPTH-1:0]       entries,
    output logic [DEPTH-1:0]            occ
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                occ[g]     <= 1'b0;
                entries[g] <= '0;
            end else if (wr_en && (wr_ptr == PW'(g))) begin
                occ[g]     <= 1'b1;
                entries[g] <= wr_entry;
            end else if (clr_en && (clr_ptr == PW'(g))) begin
                occ[g]     <= 1'b0;
            end
        end
    end

    // R4: the retired slot is released unless refilled in the same cycle
    p_head_released_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(wr_en && (wr_ptr == clr_ptr))) |=> !occ[$past(clr_ptr)]);

    // R2: a written slot is held on the next cycle
    p_slot_taken_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> occ[$past(wr_ptr)]);

endmodule

// File: rtl/sb_search.sv
module sb_search
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  sb_entry_t [DEPTH-1:0] entries,
    input  logic [DEPTH-1:0]      occ,
    input  logic                  drop_en,
    input  logic [PW-1:0]         drop_ptr,
    input  reg_idx_t              src_a,
    input  reg_idx_t              src_b,
    output logic                  stall
);

    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic dropped;
        assign dropped = drop_en && (drop_ptr == PW'(g));
        assign hit[g]  = occ[g] && !dropped && entry_hits(entries[g], src_a, src_b);
    end

    assign stall = |hit;

    // R6: register zero on both sources never stalls
    p_zero_src_r6: assert property (@(posedge clk) disable iff (rst)
        ((src_a == '0) && (src_b == '0)) |-> !stall);

    // R3: with the only held record being retired, nothing stalls
    p_drop_first_r3: assert property (@(posedge clk) disable iff (rst)
        (drop_en && ($countones(occ) == 1)) |-> !stall);

endmodule

// File: rtl/rr_scoreboard.sv
module rr_scoreboard
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ins_req,
    input  logic                 ins_has_dst,
    input  logic [REG_IDX_W-1:0] ins_dst,
    output logic                 ins_ready,
    input  logic                 rm_req,
    input  logic [REG_IDX_W-1:0] src_a,
    input  logic [REG_IDX_W-1:0] src_b,
    output logic                 stall
);

    logic [PW-1:0]         head;
    logic [PW-1:0]         tail;
    logic                  ins_fire;
    logic                  rm_fire;
    logic                  empty;
    sb_entry_t             new_entry;
    sb_entry_t [DEPTH-1:0] entries;
    logic [DEPTH-1:0]      occ;

    assign new_entry = '{has_dst: ins_has_dst, dst: ins_dst};

    sb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .ins_req   (ins_req),
        .rm_req    (rm_req),
        .head      (head),
        .tail      (tail),
        .ins_fire  (ins_fire),
        .rm_fire   (rm_fire),
        .empty     (empty),
        .ins_ready (ins_ready)
    );

    sb_slot_array #(.DEPTH(DEPTH)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ins_fire),
        .wr_ptr   (tail),
        .wr_entry (new_entry),
        .clr_en   (rm_fire),
        .clr_ptr  (head),
        .entries  (entries),
        .occ      (occ)
    );

    sb_search #(.DEPTH(DEPTH)) u_search (
        .clk      (clk),
        .rst      (rst),
        .entries  (entries),
        .occ      (occ),
        .drop_en  (rm_fire),
        .drop_ptr (head),
        .src_a    (src_a),
        .src_b    (src_b),
        .stall    (stall)
    );

    // R1: an empty queue never stalls operand fetch
    p_empty_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        empty |-> !stall);

    // R1: occupancy bookkeeping agrees with the slot flags
    p_occ_agree_r1: assert property (@(posedge clk) disable iff (rst)
        empty == (occ == '0));

    // R7: an empty queue always accepts
    p_ready_when_empty_r7: assert property (@(posedge clk) disable iff (rst)
        empty |-> ins_ready);

endmodule

// File: tb/test_rr_scoreboard.sv
module test_rr_scoreboard;

    localparam int D = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ins_req = 1'b0;
    logic       ins_has_dst = 1'b0;
    logic [4:0] ins_dst = '0;
    logic       ins_ready;
    logic       rm_req = 1'b0;
    logic [4:0] src_a = '0;
    logic [4:0] src_b = '0;
    logic       stall;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rr_scoreboard #(.DEPTH(D)) i_rr_scoreboard (
        .clk         (clk),
        .rst         (rst),
        .ins_req     (ins_req),
        .ins_has_dst (ins_has_dst),
        .ins_dst     (ins_dst),
        .ins_ready   (ins_ready),
        .rm_req      (rm_req),
        .src_a       (src_a),
        .src_b       (src_b),
        .stall       (stall)
    );

    task automatic set_in(input logic iv, input logic h, input logic [4:0] d, input logic rm);
        ins_req = iv; ins_has_dst = h; ins_dst = d; rm_req = rm;
    endtask

    // commit at the rising edge, return at the falling edge with idle controls
    task automatic edge_step();
        @(posedge clk);
        @(negedge clk);
        set_in(1'b0, 1'b0, 5'd0, 1'b0);
    endtask

    task automatic chk_stall(input logic [4:0] a, input logic [4:0] b, input logic exp, input string tag);
        src_a = a; src_b = b;
        #1;
        checks++;
        if (stall !== exp) begin
            errors++;
            $display("FAIL %s: stall for src %0d/%0d = %b, expected %b", tag, a, b, stall, exp);
        end
    endtask

    task automatic chk_ready(input logic exp, input string tag);
        #1;
        checks++;
        if (ins_ready !== exp) begin
            errors++;
            $display("FAIL %s: ins_ready = %b, expected %b", tag, ins_ready, exp);
        end
    endtask

    task automatic push(input logic h, input logic [4:0] d);
        set_in(1'b1, h, d, 1'b0);
        edge_step();
    endtask

    task automatic drain(input int n);
        for (int i = 0; i < n; i++) begin
            set_in(1'b0, 1'b0, 5'd0, 1'b1);
            edge_step();
        end
    endtask

    task automatic t_reset();
        chk_stall(5'd3, 5'd5, 1'b0, "R1");
        chk_stall(5'd0, 5'd31, 1'b0, "R1");
        chk_ready(1'b1, "R1");
    endtask

    task automatic t_insert_match();
        set_in(1'b1, 1'b1, 5'd7, 1'b0);
        chk_stall(5'd7, 5'd0, 1'b0, "R10");
        edge_step();
        chk_stall(5'd7, 5'd1, 1'b1, "R2");
        chk_stall(5'd2, 5'd7, 1'b1, "R9");
        chk_stall(5'd2, 5'd3, 1'b0, "R9");
        set_in(1'b0, 1'b0, 5'd0, 1'b1);
        chk_stall(5'd7, 5'd7, 1'b0, "R3");
        edge_step();
        chk_stall(5'd7, 5'd7, 1'b0, "R4");
    endtask

    task automatic t_order();
        push(1'b1, 5'd4);
        push(1'b1, 5'd9);
        push(1'b1, 5'd4);
        set_in(1'b0, 1'b0, 5'd0, 1'b1);
        chk_stall(5'd4, 5'd0, 1'b1, "R3");
        chk_stall(5'd9, 5'd0, 1'b1, "R3");
        edge_step();
        set_in(1'b0, 1'b0, 5'd0, 1'b1);
        chk_stall(5'd9, 5'd0, 1'b0, "R3");
        chk_stall(5'd4, 5'd0, 1'b1, "R4");
        edge_step();
        chk_stall(5'd9, 5'd0, 1'b0, "R4");
        chk_stall(5'd0, 5'd4, 1'b1, "R4");
        drain(1);
        chk_stall(5'd4, 5'd9, 1'b0, "R4");
    endtask

    task automatic t_nodst_full();
        push(1'b0, 5'd6);
        chk_stall(5'd6, 5'd0, 1'b0, "R5");
        push(1'b1, 5'd0);
        chk_stall(5'd0, 5'd0, 1'b0, "R6");
        for (int i = 1; i <= D - 2; i++) begin
            chk_ready(1'b1, "R5");
            push(1'b1, 5'(i));
        end
        chk_ready(1'b0, "R5");
        set_in(1'b1, 1'b1, 5'd11, 1'b0);
        chk_ready(1'b0, "R7");
        edge_step();
        chk_stall(5'd11, 5'd0, 1'b0, "R7");
        set_in(1'b1, 1'b1, 5'd11, 1'b1);
        chk_ready(1'b1, "R7");
        edge_step();
        chk_stall(5'd11, 5'd0, 1'b1, "R7");
        chk_ready(1'b0, "R7");
        drain(D);
        chk_stall(5'd11, 5'd1, 1'b0, "R4");
        chk_ready(1'b1, "R1");
    endtask

    task automatic t_empty_remove();
        drain(2);
        chk_stall(5'd13, 5'd0, 1'b0, "R8");
        for (int i = 0; i < D; i++) begin
            chk_ready(1'b1, "R8");
            push(1'b1, 5'd13);
        end
        chk_ready(1'b0, "R8");
        chk_stall(5'd13, 5'd0, 1'b1, "R8");
        drain(D - 1);
        set_in(1'b0, 1'b0, 5'd0, 1'b1);
        chk_stall(5'd13, 5'd0, 1'b0, "R3");
        edge_step();
        chk_stall(5'd13, 5'd13, 1'b0, "R8");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_insert_match();
        t_order();
        t_nodst_full();
        t_empty_remove();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule